// File: doc/BRIEF.md
# Bus Access Width Test Target

This block is a small register target placed behind a single bus window of up to 4 KiB. It lets software confirm that a host issues byte, halfword and word writes correctly, including how they are placed on the byte lanes. Software selects a numbered test by writing a selector byte. The block then reports three things for that test: the access width to use, the byte offset to write, and the value to write. Every write that lands on that offset with that width and that value advances a hit counter. A short zero-terminated ASCII identifier follows the header.

Tests are numbered from zero with no gaps. Software can therefore scan upward and stop at the first selector whose width code reads as 0. Three tests are built in. Test 0 is a byte write of `0x5A` at offset `0x103`. Test 1 is a halfword write of `0xA55A` at offset `0x202`. Test 2 is a word write of `0xC3A59612` at offset `0x300`.

The bus is a 32-bit little-endian word bus. `addr_i[1:0]` is ignored. Byte lane k (`be_i[k]`, `wdata_i[8k+7:8k]`) carries byte address `{addr_i[ADDR_W-1:2], k}`. A read issued with `re_i` is returned on `rdata_o` after the next rising clock edge. `rdata_o` holds its value while `re_i` is low.

Top module: `acc_test_target`

## Requirements
- R1: After reset, test 0 is selected and the hit count is 0. A read of word 0 returns `0x0000_0100` and a read of word 3 returns 0.
- R2: Byte 1 of word 0 (byte address 1) reads as the width code of the selected test: 1, 2 or 4 for tests 0, 1 and 2, and 0 for any selector of 3 or more. Bytes 0, 2 and 3 of word 0 read as 0.
- R3: Word 1 (byte address 4) reads as the target offset of the selected test: `0x103`, `0x202` or `0x300`. Word 2 (byte address 8) reads as the expected value: `0x5A`, `0xA55A` or `0xC3A59612`. Both words read as 0 for an unsupported selector.
- R4: A write counts as a hit and increments the count by one when three conditions hold. Its word address must equal the offset with the low two bits dropped. `be_i` must equal the lane mask formed from `width` contiguous ones shifted left by `offset[1:0]`. The enabled lanes must carry the expected value shifted left by `8*offset[1:0]` bits.
- R5: A write that differs from a hit in word address, in any byte-enable bit, or in any enabled data byte leaves the count unchanged. No write ever counts while an unsupported test is selected.
- R6: The count saturates at `2^CNT_W-1` and does not wrap. Word 3 (byte address 12) reads as the count, zero-extended.
- R7: A write to word 0 with `be_i[0]` set loads `wdata_i[7:0]` as the selector and clears the count to 0.
- R8: Writes to words 1, 2 and 3 are ignored, and so are writes to word 0 that have `be_i[0]` clear. They change neither the selector nor the count.
- R9: Byte addresses 16 to 23 hold the ASCII string `wr-probe`, little endian, followed by a zero byte. Every address not described above reads as 0.
- R10: `rdata_o` changes only on the clock edge that samples `re_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address; bits [1:0] ignored |
| be_i | input | 4 | Byte-lane enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |

## Verification
The hard case is a write that nearly qualifies as a hit. It has the right word but a neighbouring lane mask, or the right lanes but a single wrong bit. Only the count reveals whether such a write was taken as a hit. For each supported test the bench therefore clears the count, sweeps all fifteen non-zero byte-enable patterns at the target word, and adds writes with a corrupted byte and a wrong word. It then expects the count to read exactly 1. Saturation is reached by instantiating a 4-bit counter and issuing twenty qualifying writes.

// File: rtl/acc_test_pkg.sv
package acc_test_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned LANES     = DATA_W / 8;
  localparam int unsigned NUM_TESTS = 3;
  localparam int unsigned NAME_LEN  = 8;
  localparam int unsigned NAME_WORD = 4;                      // first word of name
  localparam int unsigned NAME_WRDS = (NAME_LEN + 1 + LANES - 1) / LANES;

  typedef struct packed {
    logic [7:0]        width;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] data;
  } test_desc_t;

  function automatic test_desc_t test_desc(input logic [7:0] sel);
    test_desc_t d;
    d = '0;
    case (sel)
      8'd0: begin d.width = 8'd1; d.offset = 32'h0000_0103; d.data = 32'h0000_005A; end
      8'd1: begin d.width = 8'd2; d.offset = 32'h0000_0202; d.data = 32'h0000_A55A; end
      8'd2: begin d.width = 8'd4; d.offset = 32'h0000_0300; d.data = 32'hC3A5_9612; end
      default: d = '0;
    endcase
    return d;
  endfunction

  function automatic logic [7:0] name_char(input int unsigned idx);
    case (idx)
      0: return 8'h77;  // w
      1: return 8'h72;  // r
      2: return 8'h2D;  // -
      3: return 8'h70;  // p
      4: return 8'h72;  // r
      5: return 8'h6F;  // o
      6: return 8'h62;  // b
      7: return 8'h65;  // e
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/acc_test_table.sv
module acc_test_table
  import acc_test_pkg::*;
(
  input  logic [7:0]        sel_i,
  output logic [7:0]        width_o,
  output logic [DATA_W-1:0] offset_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  lane_mask_o,
  output logic [DATA_W-1:0] lane_data_o
);
  test_desc_t desc;
  logic [1:0] sub;

  always_comb begin
    desc        = test_desc(sel_i);
    width_o     = desc.width;
    offset_o    = desc.offset;
    data_o      = desc.data;
    sub         = desc.offset[1:0];
    case (desc.width)
      8'd1:    lane_mask_o = LANES'(4'b0001) << sub;
      8'd2:    lane_mask_o = LANES'(4'b0011) << sub;
      8'd4:    lane_mask_o = LANES'(4'b1111);
      default: lane_mask_o = '0;
    endcase
    lane_data_o = desc.data << {sub, 3'b000};
  end
endmodule

// File: rtl/acc_write_matcher.sv
module acc_write_matcher
  import acc_test_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                we_i,
  input  logic [ADDR_W-1:2]   word_i,
  input  logic [LANES-1:0]    be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W-1:0]   offset_i,
  input  logic [LANES-1:0]    lane_mask_i,
  input  logic [DATA_W-1:0]   lane_data_i,
  output logic                hit_o
);
  logic [DATA_W-1:0] bit_mask;
  logic              addr_ok, be_ok, data_ok;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bit_mask[8*l +: 8] = {8{lane_mask_i[l]}};
  end

  always_comb begin
    addr_ok = (word_i == offset_i[ADDR_W-1:2]) && (offset_i[DATA_W-1:ADDR_W] == '0);
    be_ok   = (lane_mask_i != '0) && (be_i == lane_mask_i);
    data_ok = ((wdata_i ^ lane_data_i) & bit_mask) == '0;
    hit_o   = we_i && addr_ok && be_ok && data_ok;
  end
endmodule

// File: rtl/acc_hit_counter.sv
module acc_hit_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clr_i)                      cnt_o <= '0;
    else if (hit_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/acc_read_mux.sv
module acc_read_mux
  import acc_test_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input  logic [ADDR_W-1:2]  word_i,
  input  logic [7:0]         width_i,
  input  logic [DATA_W-1:0]  offset_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  int unsigned widx;

  always_comb begin
    widx    = int'(word_i);
    rdata_o = '0;
    if (widx == 0)      rdata_o = {16'h0000, width_i, 8'h00};
    else if (widx == 1) rdata_o = offset_i;
    else if (widx == 2) rdata_o = data_i;
    else if (widx == 3) rdata_o = DATA_W'(cnt_i);
    else if (widx >= NAME_WORD && widx < NAME_WORD + NAME_WRDS) begin
      for (int b = 0; b < LANES; b++)
        rdata_o[8*b +: 8] = name_char((widx - NAME_WORD) * LANES + b);
    end
  end
endmodule

// File: rtl/acc_test_target.sv
module acc_test_target
  import acc_test_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  logic [7:0]        sel_q;
  logic [7:0]        width;
  logic [DATA_W-1:0] offset, data, lane_data;
  logic [LANES-1:0]  lane_mask;
  logic              sel_wr, hit;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rd_mux;
  logic [ADDR_W-1:2] word;

  assign word   = addr_i[ADDR_W-1:2];
  assign sel_wr = we_i && (word == '0) && be_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= 8'd0;
    else if (sel_wr) sel_q <= wdata_i[7:0];
  end

  acc_test_table u_table (
    .sel_i       (sel_q),
    .width_o     (width),
    .offset_o    (offset),
    .data_o      (data),
    .lane_mask_o (lane_mask),
    .lane_data_o (lane_data)
  );

  acc_write_matcher #(.ADDR_W(ADDR_W)) u_match (
    .we_i        (we_i),
    .word_i      (word),
    .be_i        (be_i),
    .wdata_i     (wdata_i),
    .offset_i    (offset),
    .lane_mask_i (lane_mask),
    .lane_data_i (lane_data),
    .hit_o       (hit)
  );

  acc_hit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sel_wr),
    .hit_i  (hit),
    .cnt_o  (cnt_q)
  );

  acc_read_mux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rmux (
    .word_i   (word),
    .width_i  (width),
    .offset_i (offset),
    .data_i   (data),
    .cnt_i    (cnt_q),
    .rdata_o  (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/acc_test_target_chk.sv
module acc_test_target_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             re_i,
  input logic             sel_wr_i,
  input logic             hit_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [31:0]      rdata_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R4: a qualifying write below the ceiling advances the count by one
  assert_hit_increments_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !sel_wr_i && cnt_i != CNT_MAX) |=> cnt_i == $past(cnt_i) + 1'b1);

  assert_no_stray_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !sel_wr_i) |=> $stable(cnt_i));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_MAX && !sel_wr_i) |=> cnt_i == CNT_MAX);

  assert_select_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr_i |=> cnt_i == '0);

  assert_select_not_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_wr_i && hit_i));

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_i));
endmodule

bind acc_test_target acc_test_target_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .re_i     (re_i),
  .sel_wr_i (sel_wr),
  .hit_i    (hit),
  .cnt_i    (cnt_q),
  .rdata_i  (rdata_o)
);

// File: tb/acc_test_target_tb.sv
`timescale 1ns/1ps
module acc_test_target_tb;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned CNT_W  = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0, re_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [3:0]        be_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  acc_test_target #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .be_i, .wdata_i, .rdata_o
  );

  function automatic int unsigned e_width(int t);
    return (t >= 0 && t < 3) ? (1 << t) : 0;
  endfunction
  function automatic logic [31:0] e_off(int t);
    case (t) 0: return 32'h103; 1: return 32'h202; 2: return 32'h300; default: return 0; endcase
  endfunction
  function automatic logic [31:0] e_data(int t);
    case (t) 0: return 32'h5A; 1: return 32'hA55A; 2: return 32'hC3A59612; default: return 0; endcase
  endfunction
  function automatic logic [3:0] e_mask(int t);
    int unsigned w = e_width(t);
    if (w == 0) return 4'b0;
    return 4'(((1 << w) - 1) << (e_off(t) % 4));
  endfunction
  function automatic logic [31:0] e_lane(int t);
    return e_data(t) << (8 * (e_off(t) % 4));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; be_i = be; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; be_i = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic select(input int t);
    wr(12'h000, 4'b0001, 32'(t));
  endtask

  initial begin
    repeat (2000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, hold;
    string nm;
    nm = "wr-probe";
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(12'h000, r); check("R1 word0 after reset", r, 32'h0000_0100);
    rd(12'h00C, r); check("R1 count after reset", r, 0);

    // R2/R3 sweep selectors
    for (int t = 0; t < 8; t++) begin
      select(t);
      rd(12'h000, r); check($sformatf("R2 width sel %0d", t), r, {16'h0, 8'(e_width(t)), 8'h0});
      rd(12'h004, r); check($sformatf("R3 offset sel %0d", t), r, e_off(t));
      rd(12'h008, r); check($sformatf("R3 data sel %0d", t), r, e_data(t));
    end

    // R4/R5 byte-enable sweep, wrong data, wrong word
    for (int t = 0; t < 3; t++) begin
      logic [ADDR_W-1:0] wa;
      logic [31:0] bad;
      int exp_cnt;
      wa = ADDR_W'(e_off(t) & 32'hFFC);
      select(t);
      exp_cnt = 0;
      for (int be = 1; be < 16; be++) begin
        wr(wa, 4'(be), e_lane(t));
        if (4'(be) == e_mask(t)) exp_cnt++;
      end
      rd(12'h00C, r); check($sformatf("R4 sweep count test %0d", t), r, 32'(exp_cnt));
      bad = e_lane(t) ^ (32'h1 << (8 * (e_off(t) % 4) + 3));
      wr(wa, e_mask(t), bad);
      wr(wa + 4, e_mask(t), e_lane(t));
      wr(wa - 4, e_mask(t), e_lane(t));
      rd(12'h00C, r); check($sformatf("R5 near-miss count test %0d", t), r, 1);
    end

    // R5 unsupported selector never counts
    select(5);
    for (int t = 0; t < 3; t++) wr(ADDR_W'(e_off(t) & 32'hFFC), e_mask(t), e_lane(t));
    rd(12'h00C, r); check("R5 unsupported count", r, 0);

    // R6 saturation
    select(2);
    for (int i = 0; i < 7; i++) wr(12'h300, 4'hF, e_lane(2));
    rd(12'h00C, r); check("R6 count mid", r, 7);
    for (int i = 0; i < 13; i++) wr(12'h300, 4'hF, e_lane(2));
    rd(12'h00C, r); check("R6 count saturated", r, 32'((1 << CNT_W) - 1));

    // R8 read-only header writes ignored
    wr(12'h004, 4'hF, 32'hFFFF_FFFF);
    wr(12'h008, 4'hF, 32'hFFFF_FFFF);
    wr(12'h00C, 4'hF, 32'h0);
    wr(12'h000, 4'b1110, 32'hFFFF_FF01);
    rd(12'h000, r); check("R8 width unchanged", r, 32'h0000_0400);
    rd(12'h004, r); check("R8 offset unchanged", r, e_off(2));
    rd(12'h008, r); check("R8 data unchanged", r, e_data(2));
    rd(12'h00C, r); check("R8 count unchanged", r, 32'((1 << CNT_W) - 1));

    // R7 select clears count
    select(2);
    rd(12'h00C, r); check("R7 count cleared", r, 0);
    select(1);
    wr(12'h200, 4'b1100, e_lane(1));
    select(1);
    rd(12'h00C, r); check("R7 reselect clears", r, 0);

    // R9 name and unimplemented space
    for (int w = 0; w < 3; w++) begin
      logic [31:0] ex;
      ex = 0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < nm.len()) ex[8*b +: 8] = nm[w * 4 + b];
      rd(ADDR_W'(16 + 4 * w), r); check($sformatf("R9 name word %0d", w), r, ex);
    end
    rd(12'h01C, r); check("R9 after name", r, 0);
    rd(12'h100, r); check("R9 target word reads zero", r, 0);
    rd(12'hFFC, r); check("R9 top of window", r, 0);

    // R10 hold when not reading
    rd(12'h000, hold);
    @(negedge clk_i); addr_i = 12'h004;
    repeat (3) @(negedge clk_i);
    check("R10 rdata held", rdata_o, hold);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule